// File: doc/BRIEF.md
# Single-Precision Sign Splice and Min/Max Unit

This unit performs the single-precision floating-point operations that never round: three ways of building a result sign from two operands, and selection of the smaller or larger of two operands. Each operation works only by choosing or splicing bit patterns. The unit accepts one operation per cycle, qualified by a valid strobe. It returns the 32-bit result and a five-bit exception flag vector one clock later.

Minimum and maximum follow a fixed precedence:

1. The pair negative zero / positive zero is resolved first.
2. A pair of NaNs comes next.
3. A single NaN comes after that.
4. An ordinary quiet comparison decides everything else.

Signaling NaNs raise the invalid flag, as a quiet comparison would. The sign operations never raise a flag.

Top module: `fpSelectUnit`

## Requirements
- R1: `outValid` is high in the cycle right after a cycle with `inValid` high, and low after a cycle with `inValid` low.
- R2: With `opSel` = 0, the result is bits 30:0 of `opA` with bit 31 copied from `opB`.
- R3: With `opSel` = 1, the result is bits 30:0 of `opA` with bit 31 equal to the inverse of bit 31 of `opB`.
- R4: With `opSel` = 2, the result is `opA` with bit 31 replaced by `opA[31]` XOR `opB[31]`.
- R5: With `opSel` = 3 (min), the result is `opA` when `opA` is quietly less than `opB`, and `opB` otherwise. With `opSel` = 4 (max), the result is `opB` when `opA` is quietly less than `opB`, and `opA` otherwise. Two zeros of any sign compare equal.
- R6: When `opA` = 0x80000000 and `opB` = 0x00000000, min returns `opA` and max returns `opB`. This rule takes precedence over all the others.
- R7: When both operands are NaN (exponent all ones, mantissa non-zero), min and max return 0x7fc00000.
- R8: When exactly one operand is NaN, min and max return the other operand unchanged.
- R9: `outFlags` bit 4 (invalid) is set for min or max when either operand is a signaling NaN (exponent all ones, mantissa non-zero, bit 22 clear). Bits 3:0 are always zero. All flags are zero for `opSel` 0 to 2.
- R10: Reserved `opSel` values 5 to 7 produce a result of zero and flags of zero, with `outValid` set as in R1.
- R11: After reset, `outValid`, `outResult` and `outFlags` are zero. `outResult` and `outFlags` keep their value through cycles with `inValid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operands and select are valid this cycle |
| opSel | input | 3 | 0 copy sign, 1 negated sign, 2 xor sign, 3 min, 4 max, 5-7 reserved |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| outValid | output | 1 | Result and flags are new this cycle |
| outResult | output | 32 | Registered result |
| outFlags | output | 5 | Bit 4 invalid, bit 3 divide by zero, bit 2 overflow, bit 1 underflow, bit 0 inexact |

## Verification
All state sits in one stage, so any fault shows at the ports one cycle after the operation that triggers it. A wrong decoded strobe appears as the wrong sign bit, or as a min/max result picked from the wrong precedence rule. A stuck capture enable shows up as a result that changes while `inValid` is low, or that fails to change when it is high. The cases that need direct stimulus are the signed-zero pair in both orders, NaN pairs that mix quiet and signaling operands, and equal-magnitude negative values.

// File: rtl/fpSelectPkg.sv
package fpSelectPkg;
  localparam int EXP_W = 8;
  localparam int MAN_W = 23;
  localparam int DATA_W = EXP_W + MAN_W + 1;
  localparam int FLAG_W = 5;
  localparam int INVALID_BIT = FLAG_W - 1;
  localparam int OPSEL_W = 3;
  localparam int QUIET_BIT = MAN_W - 1;

  localparam logic [DATA_W-1:0] CANON_NAN =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] NEG_ZERO = {1'b1, {(DATA_W-1){1'b0}}};

  typedef enum logic [OPSEL_W-1:0] {
    OP_SIGN_COPY = 3'd0,
    OP_SIGN_NEG  = 3'd1,
    OP_SIGN_XOR  = 3'd2,
    OP_MIN       = 3'd3,
    OP_MAX       = 3'd4
  } opKind_e;

  typedef enum logic [1:0] {
    SGN_COPY = 2'd0,
    SGN_NEG  = 2'd1,
    SGN_XOR  = 2'd2
  } sgnMode_e;

  typedef struct packed {
    logic     load;
    logic     doSign;
    logic     doMinMax;
    logic     wantMax;
    sgnMode_e sgnMode;
  } ctrlStrobe_t;
endpackage

// File: rtl/fpOperandClass.sv
module fpOperandClass
  import fpSelectPkg::*;
(
  input  logic [DATA_W-1:0] value,
  output logic              isNan,
  output logic              isSnan,
  output logic              isZero
);
  logic expOnes;
  logic manNonZero;

  assign expOnes    = &value[DATA_W-2:MAN_W];
  assign manNonZero = |value[MAN_W-1:0];
  assign isNan      = expOnes && manNonZero;
  assign isSnan     = isNan && !value[QUIET_BIT];
  assign isZero     = (value[DATA_W-2:0] == '0);
endmodule

// File: rtl/fpSelectCtrl.sv
module fpSelectCtrl
  import fpSelectPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [OPSEL_W-1:0] opSel,
  output ctrlStrobe_t        strobe,
  output logic               outValid
);
  always_comb begin
    strobe          = '0;
    strobe.load     = inValid;
    strobe.sgnMode  = SGN_COPY;
    case (opSel)
      OP_SIGN_COPY: begin strobe.doSign = 1'b1; strobe.sgnMode = SGN_COPY; end
      OP_SIGN_NEG:  begin strobe.doSign = 1'b1; strobe.sgnMode = SGN_NEG;  end
      OP_SIGN_XOR:  begin strobe.doSign = 1'b1; strobe.sgnMode = SGN_XOR;  end
      OP_MIN:       begin strobe.doMinMax = 1'b1; end
      OP_MAX:       begin strobe.doMinMax = 1'b1; strobe.wantMax = 1'b1; end
      default:      ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end
endmodule

// File: rtl/fpSelectPath.sv
module fpSelectPath
  import fpSelectPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] result,
  output logic [FLAG_W-1:0] flags
);
  logic [1:0][DATA_W-1:0] operand;
  logic [1:0] nanV;
  logic [1:0] snanV;
  logic [1:0] zeroV;

  assign operand[0] = opA;
  assign operand[1] = opB;

  for (genvar i = 0; i < 2; i++) begin : g_class
    fpOperandClass uClass (
      .value (operand[i]),
      .isNan (nanV[i]),
      .isSnan(snanV[i]),
      .isZero(zeroV[i])
    );
  end

  logic                aNeg, bNeg;
  logic [DATA_W-2:0]   magA, magB;
  logic                quietLt;
  logic [DATA_W-1:0]   minMaxVal;
  logic                sgnBit;
  logic [DATA_W-1:0]   nextResult;
  logic [FLAG_W-1:0]   nextFlags;

  assign aNeg = opA[DATA_W-1];
  assign bNeg = opB[DATA_W-1];
  assign magA = opA[DATA_W-2:0];
  assign magB = opB[DATA_W-2:0];

  always_comb begin
    if (zeroV[0] && zeroV[1])  quietLt = 1'b0;
    else if (aNeg != bNeg)     quietLt = aNeg;
    else if (!aNeg)            quietLt = (magA < magB);
    else                       quietLt = (magA > magB);
  end

  always_comb begin
    if (opA == NEG_ZERO && opB == '0)  minMaxVal = strobe.wantMax ? opB : opA;
    else if (nanV[0] && nanV[1])       minMaxVal = CANON_NAN;
    else if (nanV[1])                  minMaxVal = opA;
    else if (nanV[0])                  minMaxVal = opB;
    else                               minMaxVal = (quietLt ^ strobe.wantMax) ? opA : opB;
  end

  always_comb begin
    case (strobe.sgnMode)
      SGN_NEG: sgnBit = ~bNeg;
      SGN_XOR: sgnBit = aNeg ^ bNeg;
      default: sgnBit = bNeg;
    endcase
  end

  always_comb begin
    nextFlags = '0;
    if (strobe.doMinMax) begin
      nextResult = minMaxVal;
      nextFlags[INVALID_BIT] = |snanV;
    end else if (strobe.doSign) begin
      nextResult = {sgnBit, magA};
    end else begin
      nextResult = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result <= '0;
      flags  <= '0;
    end else if (strobe.load) begin
      result <= nextResult;
      flags  <= nextFlags;
    end
  end
endmodule

// File: rtl/fpSelectUnit.sv
module fpSelectUnit
  import fpSelectPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [OPSEL_W-1:0] opSel,
  input  logic [DATA_W-1:0]  opA,
  input  logic [DATA_W-1:0]  opB,
  output logic               outValid,
  output logic [DATA_W-1:0]  outResult,
  output logic [FLAG_W-1:0]  outFlags
);
  ctrlStrobe_t strobe;

  fpSelectCtrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .opSel   (opSel),
    .strobe  (strobe),
    .outValid(outValid)
  );

  fpSelectPath uPath (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .opA   (opA),
    .opB   (opB),
    .result(outResult),
    .flags (outFlags)
  );
endmodule

// File: rtl/fpSelectChecks.sv
module fpSelectChecks
  import fpSelectPkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               inValid,
  input logic [OPSEL_W-1:0] opSel,
  input logic [DATA_W-1:0]  opA,
  input logic [DATA_W-1:0]  opB,
  input logic               outValid,
  input logic [DATA_W-1:0]  outResult,
  input logic [FLAG_W-1:0]  outFlags
);
  logic aNan, bNan;
  assign aNan = (&opA[DATA_W-2:MAN_W]) && (|opA[MAN_W-1:0]);
  assign bNan = (&opB[DATA_W-2:MAN_W]) && (|opB[MAN_W-1:0]);

  p_valid_rise_r1: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  p_valid_low_r1: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  p_sign_copy_r2: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opSel == OP_SIGN_COPY) |=>
      outResult == {$past(opB[DATA_W-1]), $past(opA[DATA_W-2:0])});
  p_sign_neg_r3: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opSel == OP_SIGN_NEG) |=>
      outResult == {~$past(opB[DATA_W-1]), $past(opA[DATA_W-2:0])});
  p_both_nan_r7: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (opSel == OP_MIN || opSel == OP_MAX) && aNan && bNan) |=>
      outResult == CANON_NAN);
  p_sign_no_flag_r9: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opSel < OP_MIN) |=> outFlags == '0);
  p_reserved_r10: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && opSel > OP_MAX) |=> (outResult == '0 && outFlags == '0));
  p_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(outResult) && $stable(outFlags)));
endmodule

bind fpSelectUnit fpSelectChecks uChecks (.*);

// File: tb/fpSelectUnit_test.sv
module fpSelectUnit_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [2:0]  opSel = '0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic        outValid;
  logic [31:0] outResult;
  logic [4:0]  outFlags;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  fpSelectUnit uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opSel(opSel),
    .opA(opA), .opB(opB), .outValid(outValid),
    .outResult(outResult), .outFlags(outFlags)
  );

  function automatic bit isNanF(logic [31:0] v);
    return (v[30:23] == 8'hff) && (v[22:0] != 0);
  endfunction

  function automatic bit isSnanF(logic [31:0] v);
    return isNanF(v) && !v[22];
  endfunction

  function automatic bit lessQ(logic [31:0] a, logic [31:0] b);
    if (a[30:0] == 0 && b[30:0] == 0) return 1'b0;
    if (a[31] && !b[31]) return 1'b1;
    if (!a[31] && b[31]) return 1'b0;
    if (!a[31]) return a[30:0] < b[30:0];
    return a[30:0] > b[30:0];
  endfunction

  function automatic logic [31:0] expResult(logic [2:0] op, logic [31:0] a, logic [31:0] b);
    case (op)
      3'd0: return {b[31], a[30:0]};
      3'd1: return {~b[31], a[30:0]};
      3'd2: return {a[31] ^ b[31], a[30:0]};
      3'd3, 3'd4: begin
        if (a == 32'h80000000 && b == 32'h0) return (op == 3'd4) ? b : a;
        if (isNanF(a) && isNanF(b)) return 32'h7fc00000;
        if (isNanF(b)) return a;
        if (isNanF(a)) return b;
        if (op == 3'd3) return lessQ(a, b) ? a : b;
        return lessQ(a, b) ? b : a;
      end
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [4:0] expFlags(logic [2:0] op, logic [31:0] a, logic [31:0] b);
    if ((op == 3'd3 || op == 3'd4) && (isSnanF(a) || isSnanF(b))) return 5'b10000;
    return 5'b00000;
  endfunction

  function automatic string tagFor(logic [2:0] op, logic [31:0] a, logic [31:0] b);
    case (op)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3, 3'd4: begin
        if (a == 32'h80000000 && b == 32'h0) return "R6";
        if (isNanF(a) && isNanF(b)) return "R7";
        if (isNanF(a) || isNanF(b)) return "R8";
        return "R5";
      end
      default: return "R10";
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pickOperand();
    logic [31:0] r = $urandom;
    case ($urandom % 9)
      0: return 32'h00000000;
      1: return 32'h80000000;
      2: return {r[31], 8'hff, 1'b1, r[21:0]};
      3: return {r[31], 8'hff, 1'b0, r[21:1], 1'b1};
      4: return {r[31], 8'hff, 23'h0};
      5: return {r[31], 8'h00, r[22:0]};
      default: return r;
    endcase
  endfunction

  task automatic runOp(logic [2:0] op, logic [31:0] a, logic [31:0] b);
    string tag;
    logic [31:0] er;
    logic [4:0] ef;
    tag = tagFor(op, a, b);
    er = expResult(op, a, b);
    ef = expFlags(op, a, b);
    @(negedge clk);
    inValid = 1'b1; opSel = op; opA = a; opB = b;
    @(negedge clk);
    inValid = 1'b0;
    check("R1", {31'h0, outValid}, 32'h1);
    check(tag, outResult, er);
    check("R9", {27'h0, outFlags}, {27'h0, ef});
    if ($urandom % 4 == 0) begin
      opSel = 3'($urandom); opA = $urandom; opB = $urandom;
      @(negedge clk);
      check("R1", {31'h0, outValid}, 32'h0);
      check("R11", outResult, er);
      check("R11", {27'h0, outFlags}, {27'h0, ef});
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R11", {31'h0, outValid}, 32'h0);
    check("R11", outResult, 32'h0);
    check("R11", {27'h0, outFlags}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R11", {31'h0, outValid}, 32'h0);
    // directed corners
    runOp(3'd0, 32'h3f800000, 32'h80000000);
    runOp(3'd1, 32'hbf800000, 32'h80000000);
    runOp(3'd2, 32'hbf800000, 32'hc0000000);
    runOp(3'd3, 32'h80000000, 32'h00000000);
    runOp(3'd4, 32'h80000000, 32'h00000000);
    runOp(3'd3, 32'h00000000, 32'h80000000);
    runOp(3'd4, 32'h00000000, 32'h80000000);
    runOp(3'd3, 32'h7fc00000, 32'h7f800001);
    runOp(3'd4, 32'hff800001, 32'hffc00123);
    runOp(3'd3, 32'h7f800001, 32'h3f800000);
    runOp(3'd4, 32'h40000000, 32'h7fc00000);
    runOp(3'd3, 32'hc0000000, 32'hbf800000);
    runOp(3'd4, 32'hc0000000, 32'hbf800000);
    runOp(3'd3, 32'h3f800000, 32'h3f800000);
    runOp(3'd5, 32'h3f800000, 32'h40000000);
    runOp(3'd7, 32'h7f800001, 32'h7f800001);
    for (int i = 0; i < 600; i++) begin
      runOp(3'($urandom % 8), pickOperand(), pickOperand());
    end
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule